// File: doc/BRIEF.md
# Ordered Two-Threshold Zero-Crossing Timestamper

This block measures when a line voltage crosses zero in the rising direction. A sense front end delivers two asynchronous polarity levels. One level is high while the voltage sits below a small negative threshold. The other level is high while the voltage sits above a small positive threshold. Each level is first brought into the clock domain. A level change must then hold for a minimum number of clocks before it counts, so short noise spikes are dropped. Two edges are time-stamped against a 16-bit free-running timer: the rising edge of the negative-side level and the falling edge of the positive-side level.

A crossing is accepted only when the two edges arrive in the required order: the negative-side edge first, then the positive-side edge. The reported crossing time is the midpoint of the two stamps, computed modulo 2^16 so that a timer wrap between the stamps is harmless. With each accepted crossing the block also reports the raw period since the previous accepted crossing. A downstream phase-tracking loop consumes the crossing time and the period on a one-cycle strobe. The timer advances on a tick-enable input, which is driven at the time-base rate (nominally 2.5 MHz). The timer value is also visible on a port so the consumer shares the same time base.

Top module: `zc_stamp`

## Requirements
- R1: After reset, `cross_valid` and `period_valid` are 0, and `timer_q`, `cross_time` and `period` are all 0.
- R2: `timer_q` is a 16-bit counter. It increments by one (wrapping from 0xFFFF to 0x0000) on each clock where `tick_en` is 1, and it holds its value otherwise.
- R3: Each polarity input passes through a two-flop synchronizer and a persistence filter. A change of level that lasts fewer than `FILT_CYC` consecutive clocks (default 4) is discarded and produces no edge.
- R4: A rising edge of the filtered `neg_level`, followed later by a falling edge of the filtered `pos_level`, produces exactly one accepted crossing.
- R5: The crossing time is t_n + (((t_p − t_n) mod 65536) >> 1). Here t_n is the timer value stamped at the negative-side rising edge and t_p is the one stamped at the positive-side falling edge. The shift discards the remainder, and the result is taken mod 65536.
- R6: A falling edge of `pos_level` with no pending negative-side edge is ignored. A further rising edge of `neg_level` while a pair is pending is also ignored, and the first stamp is kept.
- R7: `cross_valid` is high for exactly one clock per accepted crossing. It rises only after the positive-side edge that completes the pair.
- R8: `period` is (this crossing − previous accepted crossing) mod 65536. `period_valid` pulses with `cross_valid`, except on the first accepted crossing after reset, where it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Time-base enable; the timer advances on clocks where this is high |
| neg_level | input | 1 | Asynchronous level, high while the voltage is below the negative threshold |
| pos_level | input | 1 | Asynchronous level, high while the voltage is above the positive threshold |
| timer_q | output | 16 | Current free-running timer value |
| cross_time | output | 16 | Interpolated crossing time of the latest accepted pair |
| cross_valid | output | 1 | One-clock strobe marking a new crossing |
| period | output | 16 | Timer ticks between the latest two accepted crossings |
| period_valid | output | 1 | Strobe marking that `period` holds a real interval |

## Verification
Randomly sized intervals between the two edges exercise the midpoint arithmetic over odd, even and zero separations. A run placed just below the timer wrap separates correct modulo interpolation from a plain average. Out-of-order edges, a repeated negative-side edge and short pulses on either input each show whether the pairing and the persistence filter discard the right events, and whether the first stamp is kept. The period output is compared across a chain of crossings that starts at reset, which shows whether the first interval is suppressed.

// File: rtl/zc_pkg.sv
// Shared types for the zero-crossing timestamper.
// Assumes: channel indices are used by the top module to pick edges.
package zc_pkg;
    // Pairing state: waiting for the negative-side edge, or holding its stamp.
    typedef enum logic {
        PAIR_IDLE  = 1'b0,
        PAIR_ARMED = 1'b1
    } pair_st_t;

    // Channel order of the polarity input array.
    localparam int CH_NEG = 0;
    localparam int CH_POS = 1;
    localparam int N_CH   = 2;
endpackage

// File: rtl/zc_timer.sv
// Free-running time base.
// Counts up by one on each enabled clock and wraps at 2^TW.
// Assumes: tick_en is already synchronous to clk.
module zc_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    output logic [TW-1:0] count_o
);
    // Advance the counter on enabled clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)       count_o <= '0;
        else if (tick_en) count_o <= count_o + 1'b1;
    end
endmodule

// File: rtl/zc_sync_filter.sv
// Brings one asynchronous level into the clock domain through two flops.
// The synchronized level is only accepted once it has differed from the
// accepted level for FILT_CYC consecutive clocks. Rise and fall pulses are
// derived from the accepted level.
// Assumes: FILT_CYC >= 1.
module zc_sync_filter #(
    parameter int FILT_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

    logic          meta_q, sync_q;
    logic          filt_q, filt_d1_q;
    logic [CW-1:0] run_q;

    // Two-flop synchronizer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= raw_in;
            sync_q <= meta_q;
        end
    end

    // Persistence filter: count consecutive clocks of disagreement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            filt_q <= 1'b0;
        end else if (sync_q == filt_q) begin
            run_q <= '0;
        end else if (run_q == LAST) begin
            run_q  <= '0;
            filt_q <= sync_q;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    // Delayed copy of the accepted level, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) filt_d1_q <= 1'b0;
        else        filt_d1_q <= filt_q;
    end

    assign level_o = filt_q;
    assign rise_o  = filt_q & ~filt_d1_q;
    assign fall_o  = ~filt_q & filt_d1_q;
endmodule

// File: rtl/zc_pair_seq.sv
// Pairs a negative-side rising edge with a later positive-side falling edge.
// For each pair it outputs the modulo midpoint of the two stamps, and the
// modulo difference from the previous accepted midpoint.
// Assumes: edge pulses last one clock.
module zc_pair_seq
    import zc_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          neg_rise,
    input  logic          pos_fall,
    input  logic [TW-1:0] now,
    output logic [TW-1:0] cross_time,
    output logic          cross_valid,
    output logic [TW-1:0] period,
    output logic          period_valid
);
    pair_st_t      st_q;
    logic [TW-1:0] t_neg_q;
    logic [TW-1:0] prev_q;
    logic          have_prev_q;
    logic [TW-1:0] span;
    logic [TW-1:0] mid;

    // Modulo interpolation between the held stamp and the current time.
    always_comb begin
        span = now - t_neg_q;
        mid  = t_neg_q + (span >> 1);
    end

    // Pair sequencing, result registers and period history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= PAIR_IDLE;
            t_neg_q      <= '0;
            prev_q       <= '0;
            have_prev_q  <= 1'b0;
            cross_time   <= '0;
            cross_valid  <= 1'b0;
            period       <= '0;
            period_valid <= 1'b0;
        end else begin
            cross_valid  <= 1'b0;
            period_valid <= 1'b0;
            unique case (st_q)
                PAIR_IDLE: begin
                    if (neg_rise) begin
                        t_neg_q <= now;
                        st_q    <= PAIR_ARMED;
                    end
                end
                PAIR_ARMED: begin
                    if (pos_fall) begin
                        cross_time   <= mid;
                        cross_valid  <= 1'b1;
                        period       <= mid - prev_q;
                        period_valid <= have_prev_q;
                        prev_q       <= mid;
                        have_prev_q  <= 1'b1;
                        st_q         <= PAIR_IDLE;
                    end
                end
                default: st_q <= PAIR_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/zc_stamp.sv
// Top level of the zero-crossing timestamper.
// Conditions both polarity levels, runs the time base, and pairs the edges
// into crossing and period results.
// Assumes: tick_en is synchronous to clk; polarity levels may be asynchronous.
module zc_stamp
    import zc_pkg::*;
#(
    parameter int TW       = 16,
    parameter int FILT_CYC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          neg_level,
    input  logic          pos_level,
    output logic [TW-1:0] timer_q,
    output logic [TW-1:0] cross_time,
    output logic          cross_valid,
    output logic [TW-1:0] period,
    output logic          period_valid
);
    logic [N_CH-1:0] raw_lvl;
    logic [N_CH-1:0] flt_lvl;
    logic [N_CH-1:0] flt_rise;
    logic [N_CH-1:0] flt_fall;

    assign raw_lvl[CH_NEG] = neg_level;
    assign raw_lvl[CH_POS] = pos_level;

    zc_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .count_o (timer_q)
    );

    // One conditioning channel per polarity input.
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        zc_sync_filter #(.FILT_CYC(FILT_CYC)) u_cond (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_in  (raw_lvl[c]),
            .level_o (flt_lvl[c]),
            .rise_o  (flt_rise[c]),
            .fall_o  (flt_fall[c])
        );
    end

    zc_pair_seq #(.TW(TW)) u_pair (
        .clk          (clk),
        .rst_n        (rst_n),
        .neg_rise     (flt_rise[CH_NEG]),
        .pos_fall     (flt_fall[CH_POS]),
        .now          (timer_q),
        .cross_time   (cross_time),
        .cross_valid  (cross_valid),
        .period       (period),
        .period_valid (period_valid)
    );

    // Filtered levels and the unused edge directions only feed debug views.
    logic unused_ok;
    assign unused_ok = ^{flt_lvl, flt_rise[CH_POS], flt_fall[CH_NEG]};
endmodule

// File: rtl/zc_stamp_chk.sv
// Property checker for zc_stamp, attached to it with a bind.
module zc_stamp_chk #(
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick_en,
    input logic [TW-1:0] timer_q,
    input logic          cross_valid,
    input logic          period_valid
);
    logic seen_q;

    // Remember whether any crossing has been reported since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)           seen_q <= 1'b0;
        else if (cross_valid) seen_q <= 1'b1;
    end

    assert_timer_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> timer_q == TW'($past(timer_q) + 1'b1));

    assert_timer_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(timer_q));

    assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cross_valid |=> !cross_valid);

    assert_period_with_cross_R8: assert property (@(posedge clk) disable iff (!rst_n)
        period_valid |-> cross_valid);

    assert_no_first_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
        period_valid |-> seen_q);
endmodule

bind zc_stamp zc_stamp_chk #(.TW(TW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_en      (tick_en),
    .timer_q      (timer_q),
    .cross_valid  (cross_valid),
    .period_valid (period_valid)
);

// File: tb/zc_stamp_tb.sv
// Self-checking bench for zc_stamp: directed corners plus seeded random pairs.
module zc_stamp_tb;
    localparam int TW = 16;
    localparam int SETTLE = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0;
    logic          neg_level = 1'b0;
    logic          pos_level = 1'b0;
    logic [TW-1:0] timer_q, cross_time, period;
    logic          cross_valid, period_valid;

    int checks = 0;
    int fails = 0;
    int strobes = 0;
    int cyc = 0;
    logic [TW-1:0] last_cross = '0, last_period = '0;
    logic          last_pv = 1'b0;
    logic [TW-1:0] prev_mid = '0;
    logic          have_prev = 1'b0;
    logic          done = 1'b0;

    always #2.5 clk = ~clk;

    zc_stamp #(.TW(TW), .FILT_CYC(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .neg_level(neg_level), .pos_level(pos_level),
        .timer_q(timer_q), .cross_time(cross_time), .cross_valid(cross_valid),
        .period(period), .period_valid(period_valid)
    );

    // Record every strobe cycle away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && cross_valid) begin
            strobes++;
            last_cross  = cross_time;
            last_period = period;
            last_pv     = period_valid;
        end
    end

    function automatic logic [TW-1:0] exp_mid(input logic [TW-1:0] tn, input logic [TW-1:0] tp);
        logic [TW-1:0] d;
        d = tp - tn;
        return tn + (d >> 1);
    endfunction

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(negedge clk);
        end
        tick_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_neg(input logic v);
        neg_level = v;
        wait_cyc(SETTLE);
    endtask

    task automatic set_pos(input logic v);
        pos_level = v;
        wait_cyc(SETTLE);
    endtask

    // One full ordered pair; returns the two frozen stamps.
    task automatic do_pair(input int g0, input int g1, output logic [TW-1:0] tn, output logic [TW-1:0] tp);
        set_pos(1'b1);
        tick_n(g0);
        tn = timer_q;
        set_neg(1'b1);
        set_neg(1'b0);
        tick_n(g1);
        tp = timer_q;
        set_pos(1'b0);
    endtask

    // Compare the last strobe with the bench model and advance the model.
    task automatic expect_cross(input int s0, input logic [TW-1:0] tn, input logic [TW-1:0] tp, input string tag);
        logic [TW-1:0] m;
        m = exp_mid(tn, tp);
        check(strobes - s0 == 1, {tag, " R4/R7 strobe count"}, strobes - s0, 1);
        check(last_cross == m, {tag, " R5 crossing"}, last_cross, m);
        check(last_pv == have_prev, {tag, " R8 period_valid"}, last_pv, have_prev);
        if (have_prev)
            check(last_period == TW'(m - prev_mid), {tag, " R8 period"}, last_period, TW'(m - prev_mid));
        prev_mid  = m;
        have_prev = 1'b1;
    endtask

    initial begin
        logic [TW-1:0] tn, tp, tn2;
        int s0;
        void'($urandom(32'h5eed_2c01));
        wait_cyc(3);
        // R1: reset state
        check(!cross_valid && !period_valid, "R1 strobes", {cross_valid, period_valid}, 0);
        check(timer_q == 0 && cross_time == 0 && period == 0, "R1 values", timer_q | cross_time | period, 0);
        rst_n = 1'b1;
        wait_cyc(2);

        // R2: counting and holding
        tick_n(100);
        check(timer_q == 100, "R2 count", timer_q, 100);
        wait_cyc(10);
        check(timer_q == 100, "R2 hold", timer_q, 100);

        // R4/R5/R8: first pair, period suppressed
        s0 = strobes;
        do_pair(37, 51, tn, tp);
        expect_cross(s0, tn, tp, "first");

        // R4/R5: zero separation
        s0 = strobes;
        do_pair(200, 0, tn, tp);
        expect_cross(s0, tn, tp, "zero-span");

        // R6: positive-side edge with nothing pending
        s0 = strobes;
        set_pos(1'b1);
        set_pos(1'b0);
        check(strobes == s0, "R6 lone positive edge", strobes - s0, 0);

        // R6: repeated negative-side edge keeps the first stamp
        s0 = strobes;
        set_pos(1'b1);
        tick_n(10);
        tn = timer_q;
        set_neg(1'b1);
        set_neg(1'b0);
        tick_n(300);
        tn2 = timer_q;
        set_neg(1'b1);
        set_neg(1'b0);
        tick_n(77);
        tp = timer_q;
        set_pos(1'b0);
        check(last_cross != exp_mid(tn2, tp) || tn2 == tn, "R6 second stamp ignored", last_cross, exp_mid(tn, tp));
        expect_cross(s0, tn, tp, "repeat-neg");

        // R3: short negative-side pulse while idle yields no pair
        s0 = strobes;
        set_pos(1'b1);
        neg_level = 1'b1;
        wait_cyc(2);
        neg_level = 1'b0;
        wait_cyc(SETTLE);
        set_pos(1'b0);
        check(strobes == s0, "R3 neg glitch rejected", strobes - s0, 0);

        // R3: short positive-side dip while armed does not complete the pair
        s0 = strobes;
        set_pos(1'b1);
        tick_n(5);
        tn = timer_q;
        set_neg(1'b1);
        set_neg(1'b0);
        tick_n(90);
        pos_level = 1'b0;
        wait_cyc(3);
        pos_level = 1'b1;
        wait_cyc(SETTLE);
        check(strobes == s0, "R3 pos glitch rejected", strobes - s0, 0);
        tick_n(41);
        tp = timer_q;
        set_pos(1'b0);
        expect_cross(s0, tn, tp, "after-glitch");

        // R5: pair straddling the timer wrap
        while (timer_q != 16'hFFF0) begin
            tick_en = 1'b1;
            @(negedge clk);
        end
        tick_en = 1'b0;
        wait_cyc(1);
        s0 = strobes;
        set_pos(1'b1);
        tn = timer_q;
        set_neg(1'b1);
        set_neg(1'b0);
        tick_n(45);
        tp = timer_q;
        check(tp == 16'h001D, "R2 wrap", tp, 16'h001D);
        set_pos(1'b0);
        expect_cross(s0, tn, tp, "wrap");

        // Random pairs with random separations
        for (int k = 0; k < 16; k++) begin
            s0 = strobes;
            do_pair(int'($urandom_range(0, 1500)), int'($urandom_range(0, 1500)), tn, tp);
            expect_cross(s0, tn, tp, "random");
        end
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        while (!done && cyc < 190000) @(negedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule